// File: doc/BRIEF.md
# Serial and keyboard status latches with interrupt gating

This block holds the status and interrupt-control state that sits beside a serial port and a keyboard scanner. Three error conditions (receive framing error, receive overrun and keyboard overrun) arrive as one-cycle strobes. Each one clears a sticky, active-low latch. The latches stay low until software writes any value to a dedicated clear address. The latches are packed into a status byte together with live conditions taken straight from level inputs: receive shifter busy, key held, shift key held and the raw receive pin level.

A second write address loads an 8-bit enable mask. Eight interrupt sources each raise a one-cycle strobe. A strobe sets its pending bit only while its enable bit is 1. Clearing an enable bit removes its pending bit at once, and the interrupt line is the OR of all pending bits. A third write address holds a break control. While it is set, the serial transmit output is forced low whatever the transmitter drives. The shifting and scanning logic that produces the strobes and levels lives outside this block.

Top module: `sk_status_irq`

## Requirements
- R1: After synchronous reset all three error latches read 1, the enable mask is 0, no interrupt is pending, `irq_o` is 0 and break is off, so `ser_tx_o` follows `ser_tx_i`.
- R2: A strobe on `frame_err_i`, `rx_ovr_i` or `kbd_ovr_i` drives status bit 7, 6 or 5 respectively to 0 from the cycle after the strobe. The bit stays 0 until a clear write, whatever happens to the other inputs.
- R3: A write of any data value to address `ADDR_ERRCLR` returns status bits 7, 6 and 5 to 1 from the next cycle. If an error strobe arrives in the same cycle as the clear write, that latch goes to 0.
- R4: Status bits 1, 2 and 3 are active-low live copies of `rx_busy_i`, `key_held_i` and `shift_held_i`. Each bit reads 0 while its input is 1, in the same cycle and with no register in the path.
- R5: Status bit 4 equals `rx_pin_i` in the same cycle.
- R6: Status bit 0 always reads 1.
- R7: A write to address `ADDR_IRQEN` loads the enable mask. Bit i of the mask gates source `irq_evt_i[i]`, where bit 0 is timer 1, bit 1 timer 2, bit 2 timer 4, bit 3 transmit finished, bit 4 output data needed, bit 5 input data ready, bit 6 other key and bit 7 break key. A strobe on an enabled source sets `pend_o[i]` from the next cycle, and the bit then holds while the enable stays 1.
- R8: A strobe on a source whose enable bit is 0 has no effect. Its pending bit stays 0, and it stays 0 when the enable is set later.
- R9: A write that clears enable bit i clears `pend_o[i]` from the cycle after the write, while pending bits that stay enabled are kept.
- R10: `irq_o` is 1 exactly when at least one bit of `pend_o` is 1.
- R11: A write to address `ADDR_SERCTL` with data bit 7 set forces `ser_tx_o` to 0 from the next cycle. A write with bit 7 clear lets `ser_tx_o` follow `ser_tx_i` again. The other data bits have no effect.
- R12: Writes to any other address leave the status byte, the enable mask, the pending bits and `ser_tx_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 8 | Register write data |
| frame_err_i | input | 1 | Receive framing error strobe |
| rx_ovr_i | input | 1 | Receive overrun strobe |
| kbd_ovr_i | input | 1 | Keyboard overrun strobe |
| rx_busy_i | input | 1 | Receive shifter busy level |
| key_held_i | input | 1 | Last key still held level |
| shift_held_i | input | 1 | Shift key held level |
| rx_pin_i | input | 1 | Raw receive pin level |
| irq_evt_i | input | 8 | Interrupt source strobes |
| ser_tx_i | input | 1 | Transmit bit from the serializer |
| ser_tx_o | output | 1 | Transmit pin after break override |
| status_o | output | 8 | Status byte |
| pend_o | output | 8 | Pending interrupt bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps all sixteen combinations of the live inputs. A design that registered those bits, or that dropped the active-low inversion, would show the status one cycle late or with those bits inverted. Each error source is strobed on its own so that a swapped bit position shows up. An error strobe is also issued in the same cycle as a clear write. A design that let the clear win would read 1 where 0 is expected. All 256 enable masks are swept with every source firing, and a source is fired while disabled and then enabled. A design that latched masked strobes would raise stale pending bits and a false interrupt after the enable write. A design that only masked new strobes would keep the old bits after an enable is cleared.

// File: rtl/sk_pkg.sv
package sk_pkg;

    localparam int BYTE_W  = 8;
    localparam int NUM_ERR = 3;
    localparam int NUM_SRC = BYTE_W;

    // Error latch index inside the latch bank; status bit = ERR_BASE + index.
    localparam int ERR_BASE = 5;

    typedef enum logic [1:0] {
        ERR_KBD_OVR = 2'd0,
        ERR_RX_OVR  = 2'd1,
        ERR_FRAME   = 2'd2
    } err_idx_e;

    typedef enum logic [2:0] {
        SRC_TMR1    = 3'd0,
        SRC_TMR2    = 3'd1,
        SRC_TMR4    = 3'd2,
        SRC_TX_DONE = 3'd3,
        SRC_TX_NEED = 3'd4,
        SRC_RX_RDY  = 3'd5,
        SRC_KEY     = 3'd6,
        SRC_BRK_KEY = 3'd7
    } src_idx_e;

    typedef struct packed {
        logic rx_pin;
        logic shift_held;
        logic key_held;
        logic rx_busy;
    } live_t;

    typedef struct packed {
        logic                   clr;
        logic [NUM_SRC-1:0]     en;
        logic                   brk;
    } ctl_t;

    // Status byte: latches high, live conditions low, spare bit forced to 1.
    function automatic logic [BYTE_W-1:0] pack_status(
        input logic [NUM_ERR-1:0] err_n,
        input live_t              live
    );
        logic [BYTE_W-1:0] s;
        s                       = '1;
        s[ERR_BASE +: NUM_ERR]  = err_n;
        s[4]                    = live.rx_pin;
        s[3]                    = ~live.shift_held;
        s[2]                    = ~live.key_held;
        s[1]                    = ~live.rx_busy;
        return s;
    endfunction

endpackage

// File: rtl/sk_bus_decode.sv
module sk_bus_decode
    import sk_pkg::*;
#(
    parameter int              ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] ADDR_IRQEN  = 4'hE,
    parameter logic [ADDR_W-1:0] ADDR_ERRCLR = 4'hA,
    parameter logic [ADDR_W-1:0] ADDR_SERCTL = 4'hF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output ctl_t              ctl_o
);

    localparam int BRK_BIT = BYTE_W - 1;

    logic               hit_en;
    logic               hit_clr;
    logic               hit_ser;
    logic [NUM_SRC-1:0] en_q;
    logic               brk_q;

    always_comb begin
        hit_en  = wr_en_i && (wr_addr_i == ADDR_IRQEN);
        hit_clr = wr_en_i && (wr_addr_i == ADDR_ERRCLR);
        hit_ser = wr_en_i && (wr_addr_i == ADDR_SERCTL);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_q  <= '0;
            brk_q <= 1'b0;
        end else begin
            if (hit_en)  en_q  <= wr_data_i;
            if (hit_ser) brk_q <= wr_data_i[BRK_BIT];
        end
    end

    always_comb begin
        ctl_o.clr = hit_clr;
        ctl_o.en  = en_q;
        ctl_o.brk = brk_q;
    end

    AST_EN_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_en |=> (ctl_o.en == $past(wr_data_i))); // R7
    AST_EN_KEEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !hit_en |=> $stable(ctl_o.en)); // R12

endmodule

// File: rtl/sk_err_latches.sv
module sk_err_latches
    import sk_pkg::*;
#(
    parameter int N = NUM_ERR
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] lat_n_o
);

    for (genvar g = 0; g < N; g++) begin : g_lat
        logic q;

        // Event beats the clear when both land on the same edge.
        always_ff @(posedge clk_i) begin
            if (rst_i)          q <= 1'b1;
            else if (evt_i[g])  q <= 1'b0;
            else if (clr_i)     q <= 1'b1;
        end

        assign lat_n_o[g] = q;

        AST_ERR_SET: assert property (@(posedge clk_i) disable iff (rst_i)
            evt_i[g] |=> !lat_n_o[g]); // R2
        AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
            (!lat_n_o[g] && !clr_i) |=> !lat_n_o[g]); // R2
        AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
            (clr_i && !evt_i[g]) |=> lat_n_o[g]); // R3
        AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
            $fell(lat_n_o[g]) |-> $past(evt_i[g])); // R2
    end

endmodule

// File: rtl/sk_irq_pend.sv
module sk_irq_pend
    import sk_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] evt_i,
    output logic [N-1:0] pend_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic q;

        // Raw flag is flushed one edge after its enable drops, so a later
        // re-enable never revives an old request.
        always_ff @(posedge clk_i) begin
            if (rst_i)        q <= 1'b0;
            else if (!en_i[g]) q <= 1'b0;
            else if (evt_i[g]) q <= 1'b1;
        end

        assign pend_o[g] = q & en_i[g];

        AST_PEND_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(pend_o[g]) |-> $past(evt_i[g] && en_i[g])); // R8
        AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
            pend_o[g] |=> (pend_o[g] || !en_i[g])); // R7
        AST_PEND_SET: assert property (@(posedge clk_i) disable iff (rst_i)
            (evt_i[g] && en_i[g]) |=> (pend_o[g] || !en_i[g])); // R7
    end

endmodule

// File: rtl/sk_status_irq.sv
module sk_status_irq
    import sk_pkg::*;
#(
    parameter int                ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] ADDR_IRQEN  = 4'hE,
    parameter logic [ADDR_W-1:0] ADDR_ERRCLR = 4'hA,
    parameter logic [ADDR_W-1:0] ADDR_SERCTL = 4'hF
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              frame_err_i,
    input  logic              rx_ovr_i,
    input  logic              kbd_ovr_i,
    input  logic              rx_busy_i,
    input  logic              key_held_i,
    input  logic              shift_held_i,
    input  logic              rx_pin_i,
    input  logic [7:0]        irq_evt_i,
    input  logic              ser_tx_i,
    output logic              ser_tx_o,
    output logic [7:0]        status_o,
    output logic [7:0]        pend_o,
    output logic              irq_o
);

    ctl_t                ctl;
    logic [NUM_ERR-1:0]  err_evt;
    logic [NUM_ERR-1:0]  err_n;
    live_t               live;

    sk_bus_decode #(
        .ADDR_W      (ADDR_W),
        .ADDR_IRQEN  (ADDR_IRQEN),
        .ADDR_ERRCLR (ADDR_ERRCLR),
        .ADDR_SERCTL (ADDR_SERCTL)
    ) i_dec (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .ctl_o     (ctl)
    );

    always_comb begin
        err_evt                      = '0;
        err_evt[int'(ERR_KBD_OVR)]   = kbd_ovr_i;
        err_evt[int'(ERR_RX_OVR)]    = rx_ovr_i;
        err_evt[int'(ERR_FRAME)]     = frame_err_i;
    end

    sk_err_latches #(.N(NUM_ERR)) i_err (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .clr_i   (ctl.clr),
        .evt_i   (err_evt),
        .lat_n_o (err_n)
    );

    sk_irq_pend #(.N(NUM_SRC)) i_pend (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .en_i   (ctl.en),
        .evt_i  (irq_evt_i),
        .pend_o (pend_o)
    );

    always_comb begin
        live.rx_pin     = rx_pin_i;
        live.shift_held = shift_held_i;
        live.key_held   = key_held_i;
        live.rx_busy    = rx_busy_i;
        status_o        = pack_status(err_n, live);
        irq_o           = |pend_o;
        ser_tx_o        = ser_tx_i & ~ctl.brk;
    end

    AST_BREAK_FORCE: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == ADDR_SERCTL && wr_data_i[7]) |=> !ser_tx_o); // R11
    AST_SPARE_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
        status_o[0]); // R6
    AST_IRQ_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(irq_o) |-> ($countones(pend_o) > 0)); // R10
    AST_CLR_ANY: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wr_addr_i == ADDR_ERRCLR && !frame_err_i && !rx_ovr_i && !kbd_ovr_i)
        |=> (status_o[7:5] == 3'b111)); // R3

endmodule

// File: tb/test_sk_status_irq.sv
module test_sk_status_irq;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_EN  = 4'hE;
    localparam logic [3:0] A_CLR = 4'hA;
    localparam logic [3:0] A_SER = 4'hF;
    localparam logic [3:0] A_OTH = 4'h3;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       frame_err, rx_ovr, kbd_ovr;
    logic       rx_busy, key_held, shift_held, rx_pin;
    logic [7:0] irq_evt;
    logic       ser_tx_in, ser_tx_out;
    logic [7:0] status, pend;
    logic       irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model of the sticky latches (1 = no error)
    logic m_fr, m_rx, m_kb;

    always #(CLK_PERIOD/2) clk = ~clk;

    sk_status_irq i_sk_status_irq (
        .clk_i        (clk),
        .rst_i        (rst),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .frame_err_i  (frame_err),
        .rx_ovr_i     (rx_ovr),
        .kbd_ovr_i    (kbd_ovr),
        .rx_busy_i    (rx_busy),
        .key_held_i   (key_held),
        .shift_held_i (shift_held),
        .rx_pin_i     (rx_pin),
        .irq_evt_i    (irq_evt),
        .ser_tx_i     (ser_tx_in),
        .ser_tx_o     (ser_tx_out),
        .status_o     (status),
        .pend_o       (pend),
        .irq_o        (irq)
    );

    function automatic logic [7:0] exp_status();
        return {m_fr, m_rx, m_kb, rx_pin, ~shift_held, ~key_held, ~rx_busy, 1'b1};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic fire_irq(input logic [7:0] v);
        irq_evt = v;
        tick();
        irq_evt = '0;
    endtask

    task automatic fire_err(input int k);
        frame_err = (k == 2); rx_ovr = (k == 1); kbd_ovr = (k == 0);
        tick();
        frame_err = 0; rx_ovr = 0; kbd_ovr = 0;
        if (k == 2) m_fr = 0;
        if (k == 1) m_rx = 0;
        if (k == 0) m_kb = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; wr_addr = '0; wr_data = '0;
        frame_err = 0; rx_ovr = 0; kbd_ovr = 0;
        rx_busy = 0; key_held = 0; shift_held = 0; rx_pin = 1;
        irq_evt = '0; ser_tx_in = 1;
        m_fr = 1; m_rx = 1; m_kb = 1;
        repeat (3) tick();
        rst = 0;
        tick();

        // R1 reset state
        chk("R1 status", status, 8'hFF);
        chk("R1 pend", pend, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 tx", {7'd0, ser_tx_out}, 8'h01);

        // R4 R5 R6 live sweep
        for (int v = 0; v < 16; v++) begin
            {rx_pin, shift_held, key_held, rx_busy} = v[3:0];
            #1;
            chk("R4 R5 R6 live", status, exp_status());
        end
        rx_busy = 0; key_held = 0; shift_held = 0; rx_pin = 1;

        // R2 R3 each error source alone
        for (int k = 0; k < 3; k++) begin
            fire_err(k);
            chk("R2 set", status, exp_status());
            repeat (3) tick();
            rx_pin = 0; #1;
            chk("R2 sticky", status, exp_status());
            rx_pin = 1;
            wr(A_CLR, 8'(k * 8'h55));
            m_fr = 1; m_rx = 1; m_kb = 1;
            chk("R3 clear", status, exp_status());
        end

        // R3 event in same cycle as clear write: event wins
        for (int k = 0; k < 3; k++) begin
            frame_err = (k == 2); rx_ovr = (k == 1); kbd_ovr = (k == 0);
            wr(A_CLR, 8'hFF);
            frame_err = 0; rx_ovr = 0; kbd_ovr = 0;
            if (k == 2) m_fr = 0;
            if (k == 1) m_rx = 0;
            if (k == 0) m_kb = 0;
            chk("R3 collide", status, exp_status());
            wr(A_CLR, 8'h00);
            m_fr = 1; m_rx = 1; m_kb = 1;
            chk("R3 recover", status, exp_status());
        end

        // R12 other address writes
        fire_err(1);
        wr(A_OTH, 8'hFF);
        chk("R12 status", status, exp_status());
        chk("R12 tx", {7'd0, ser_tx_out}, 8'h01);
        fire_irq(8'hFF);
        chk("R12 pend", pend, 8'h00);
        wr(A_CLR, 8'h12);
        m_rx = 1;

        // R7 R10 enable sweep, all sources firing
        for (int e = 0; e < 256; e++) begin
            wr(A_EN, 8'(e));
            fire_irq(8'hFF);
            chk("R7 pend", pend, 8'(e));
            chk("R10 irq", {7'd0, irq}, {7'd0, (e != 0)});
            wr(A_EN, 8'h00);
            chk("R9 clear", pend, 8'h00);
        end

        // R7 single source mapping
        for (int i = 0; i < 8; i++) begin
            wr(A_EN, 8'hFF);
            fire_irq(8'(1 << i));
            chk("R7 one", pend, 8'(1 << i));
            chk("R10 one", {7'd0, irq}, 8'h01);
            repeat (2) tick();
            chk("R7 hold", pend, 8'(1 << i));
            wr(A_EN, 8'h00);
        end

        // R8 masked strobe leaves nothing behind
        wr(A_EN, 8'h00);
        fire_irq(8'hFF);
        chk("R8 masked", pend, 8'h00);
        wr(A_EN, 8'hFF);
        chk("R8 after enable", pend, 8'h00);
        chk("R8 irq", {7'd0, irq}, 8'h00);

        // R9 partial disable keeps enabled bits
        fire_irq(8'hFF);
        wr(A_EN, 8'hF0);
        chk("R9 partial", pend, 8'hF0);
        repeat (2) tick();
        chk("R9 kept", pend, 8'hF0);
        wr(A_EN, 8'hFF);
        chk("R9 no revive", pend, 8'hF0);
        wr(A_EN, 8'h00);
        chk("R10 off", {7'd0, irq}, 8'h00);

        // R11 break override
        ser_tx_in = 1;
        wr(A_SER, 8'h80);
        chk("R11 forced", {7'd0, ser_tx_out}, 8'h00);
        ser_tx_in = 0; #1;
        chk("R11 forced0", {7'd0, ser_tx_out}, 8'h00);
        ser_tx_in = 1;
        wr(A_SER, 8'h7F);
        chk("R11 release", {7'd0, ser_tx_out}, 8'h01);
        ser_tx_in = 0; #1;
        chk("R11 follow", {7'd0, ser_tx_out}, 8'h00);
        ser_tx_in = 1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule